// File: doc/BRIEF.md
# Synchronous-to-Asynchronous Stop-Bit Restorer

This block sits on the receive side of a modem data path, after the descrambler. The remote transmitter may have removed an occasional stop bit to absorb a small rate surplus. The block takes the synchronous bit stream, one bit per `sync_en` pulse, and finds character boundaries in it. Each character is held in a two-entry queue and then sent again on the asynchronous `rxd` line. Every character leaves with a high stop bit, including those whose stop bit was removed.

Output bit timing counts a fast `tick` enable. A normal bit lasts `TICKS_PER_BIT` ticks. The line rate rises only while another character is waiting. In that case each bit is shortened by one sixty-fourth, which keeps the intra-character rate at or below about 1215 bit/s for a 1200 bit/s line. An extended overspeed setting shortens every stop bit to seven eighths of a bit. This covers input that runs up to about 2.3 % fast. Without the setting, the block covers about 1 %.

A line held low across two whole characters is a break. It is sent on as one continuous low with no stop bit inserted, and is closed by a single stop bit once the input returns high.

Top module: `rsa_stop_restorer`

## Requirements
- R1: After reset, and whenever no character is queued or being sent, `rxd` is high.
- R2: `char_len` selects the frame length N = 8 + `char_len` (values 0..3 give 8..11 bits). A frame starts at the first low bit seen while hunting, and is followed by N-2 data bits, least significant first, and then one stop position. `rxd` carries a low start bit, the same data bits least significant first, and a high stop bit.
- R3: When the stop position of a frame holds a low bit, the character is still sent with a high stop bit. That low bit is taken as the start bit of the next frame.
- R4: With default parameters, every output bit lasts 80 ticks while no further character waits in the queue, and 79 ticks while one does. Outside a break, no level on `rxd` is shorter than 79 ticks when `ovs_ext` is low.
- R5: When `ovs_ext` is high, every output stop bit lasts 70 ticks (7/8 of a bit). Other bits follow R4.
- R6: An all-zero frame with a low stop position, followed by another all-zero frame with a low stop position, is a break. `rxd` goes low once and stays low with no high pulse until the input returns high. It then gives one stop bit and idles high, and the next character is sent normally.
- R7: An all-zero frame with a low stop position whose low run ends before a break is sent as the character 0. The character that follows is also sent. This holds even when the only high bit is the stop position of the next frame.
- R8: Characters leave in arrival order with none lost, with input up to 1 % fast when `ovs_ext` is low and 2.3 % fast when it is high. The queue is never written while full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_bit | input | 1 | Received synchronous data bit |
| sync_en | input | 1 | One-cycle strobe marking a valid `sync_bit` |
| tick | input | 1 | Fast timing enable for output bit timing |
| char_len | input | 2 | Frame length select, N = 8 + value |
| ovs_ext | input | 1 | Extended overspeed: shortened stop bits |
| rxd | output | 1 | Asynchronous serial output, idle high |

## Verification
A framer that loses count of bits shows on `rxd` within one character. The next decoded byte is shifted, or a stop bit samples low. A pending zero frame that is handled wrongly shows either as a missing 0 character or as a break low that appears where a character belongs. Wrong bit-length selection shows as a level run of the wrong length, measured edge to edge on `rxd` in the same character. A queue pointer slip shows as reordered or repeated characters within two characters.

// File: rtl/rsa_pkg.sv
package rsa_pkg;

  localparam int unsigned DATA_MAX = 9;

  typedef enum logic {
    K_CHAR  = 1'b0,
    K_BREAK = 1'b1
  } kind_e;

  typedef struct packed {
    kind_e               kind;
    logic [DATA_MAX-1:0] data;
  } entry_t;

  localparam int unsigned ENTRY_W = $bits(entry_t);

  // total frame bits including start and stop position
  function automatic int unsigned frame_bits(input logic [1:0] len);
    return 32'd8 + {30'd0, len};
  endfunction

  function automatic int unsigned data_bits(input logic [1:0] len);
    return frame_bits(len) - 32'd2;
  endfunction

  // one bit, shortened by 1/64 when a character is waiting
  function automatic int unsigned bit_ticks(input int unsigned tpb, input logic fast);
    return fast ? (tpb - tpb / 64) : tpb;
  endfunction

  // stop bit: 7/8 of a bit in extended overspeed, otherwise a plain bit
  function automatic int unsigned stop_ticks(input int unsigned tpb, input logic fast,
                                             input logic ext);
    return ext ? (tpb * 7) / 8 : bit_ticks(tpb, fast);
  endfunction

endpackage

// File: rtl/rsa_framer.sv
module rsa_framer
  import rsa_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_bit,
  input  logic        sync_en,
  input  logic [1:0]  char_len,
  output logic        push,
  output entry_t      push_entry,
  output logic        in_break
);

  typedef enum logic [1:0] {F_HUNT, F_BITS, F_BREAK} fstate_e;

  fstate_e             st;
  logic [3:0]          idx;
  logic [DATA_MAX-1:0] sh;
  logic                pend;
  logic                late_q;
  logic [DATA_MAX-1:0] late_data;

  logic [3:0] stop_idx;
  logic       bit_hit;
  logic       at_stop;
  logic       frame_end;
  logic       flush_pend;
  logic       data_zero;

  always_comb begin
    stop_idx   = 4'(frame_bits(char_len) - 1);
    bit_hit    = sync_en && (st == F_BITS);
    at_stop    = (idx == stop_idx);
    frame_end  = bit_hit && at_stop;
    flush_pend = bit_hit && pend && sync_bit;
    data_zero  = (sh == '0);

    push       = 1'b0;
    push_entry = '{kind: K_CHAR, data: '0};
    if (late_q) begin
      push            = 1'b1;
      push_entry.data = late_data;
    end else if (flush_pend) begin
      push = 1'b1;
    end else if (frame_end) begin
      if (sync_bit || !data_zero) begin
        push            = 1'b1;
        push_entry.data = sh;
      end else if (pend) begin
        push            = 1'b1;
        push_entry.kind = K_BREAK;
      end
    end
  end

  assign in_break = (st == F_BREAK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= F_HUNT;
      idx       <= '0;
      sh        <= '0;
      pend      <= 1'b0;
      late_q    <= 1'b0;
      late_data <= '0;
    end else begin
      late_q <= flush_pend && frame_end;
      if (flush_pend && frame_end) late_data <= sh;
      if (flush_pend) pend <= 1'b0;

      unique case (st)
        F_HUNT: begin
          if (sync_en && !sync_bit) begin
            st  <= F_BITS;
            idx <= 4'd1;
            sh  <= '0;
          end
        end
        F_BITS: begin
          if (sync_en) begin
            if (at_stop) begin
              if (sync_bit) begin
                st <= F_HUNT;
              end else if (data_zero && pend) begin
                st   <= F_BREAK;
                pend <= 1'b0;
              end else begin
                idx  <= 4'd1;
                sh   <= '0;
                pend <= data_zero;
              end
            end else begin
              sh[idx - 4'd1] <= sync_bit;
              idx            <= idx + 4'd1;
            end
          end
        end
        F_BREAK: begin
          if (sync_en && sync_bit) st <= F_HUNT;
        end
        default: st <= F_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/rsa_char_fifo.sv
module rsa_char_fifo #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W     = 10,
  parameter int unsigned CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    wdata,
  input  logic            pop,
  output logic [W-1:0]    rdata,
  output logic [CNTW-1:0] count,
  output logic            empty,
  output logic            full
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNTW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign rdata   = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= wdata;
        wp      <= nxt(wp);
      end
      if (do_pop) rp <= nxt(rp);
      if (do_push && !do_pop) count <= count + CNTW'(1);
      else if (do_pop && !do_push) count <= count - CNTW'(1);
    end
  end

endmodule

// File: rtl/rsa_serializer.sv
module rsa_serializer
  import rsa_pkg::*;
#(
  parameter int unsigned TPB  = 80,
  parameter int unsigned CNTW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            ovs_ext,
  input  logic [1:0]      char_len,
  input  logic            fifo_empty,
  input  logic [CNTW-1:0] fifo_count,
  input  entry_t          head,
  input  logic            in_break,
  output logic            pop,
  output logic            rxd,
  output logic            ser_idle,
  output logic            ser_break
);

  localparam int unsigned CW = $clog2(TPB + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_BRK} sstate_e;

  sstate_e             st;
  logic [CW-1:0]       cnt;
  logic [CW-1:0]       blen;
  logic [DATA_MAX-1:0] sh;
  logic [3:0]          bidx;

  logic timed, bit_done, take, more_now, more_pop, last_data;

  always_comb begin
    timed     = (st == S_START) || (st == S_DATA) || (st == S_STOP);
    bit_done  = timed && tick && (cnt == blen - CW'(1));
    take      = !fifo_empty && ((st == S_IDLE) || ((st == S_STOP) && bit_done));
    more_now  = (fifo_count != '0);
    more_pop  = (fifo_count > CNTW'(1));
    last_data = (bidx == 4'(data_bits(char_len) - 1));
    unique case (st)
      S_START: rxd = 1'b0;
      S_DATA:  rxd = sh[0];
      S_BRK:   rxd = 1'b0;
      default: rxd = 1'b1;
    endcase
  end

  assign pop       = take;
  assign ser_idle  = (st == S_IDLE);
  assign ser_break = (st == S_BRK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      blen <= CW'(TPB);
      sh   <= '0;
      bidx <= '0;
    end else if (take) begin
      cnt  <= '0;
      bidx <= '0;
      if (head.kind == K_BREAK) begin
        st <= S_BRK;
      end else begin
        st   <= S_START;
        sh   <= head.data;
        blen <= CW'(bit_ticks(TPB, more_pop));
      end
    end else begin
      unique case (st)
        S_START: begin
          if (bit_done) begin
            st   <= S_DATA;
            cnt  <= '0;
            blen <= CW'(bit_ticks(TPB, more_now));
          end else if (tick) cnt <= cnt + CW'(1);
        end
        S_DATA: begin
          if (bit_done) begin
            cnt <= '0;
            sh  <= sh >> 1;
            if (last_data) begin
              st   <= S_STOP;
              blen <= CW'(stop_ticks(TPB, more_now, ovs_ext));
            end else begin
              bidx <= bidx + 4'd1;
              blen <= CW'(bit_ticks(TPB, more_now));
            end
          end else if (tick) cnt <= cnt + CW'(1);
        end
        S_STOP: begin
          if (bit_done) st <= S_IDLE;
          else if (tick) cnt <= cnt + CW'(1);
        end
        S_BRK: begin
          if (!in_break) begin
            st   <= S_STOP;
            cnt  <= '0;
            blen <= CW'(TPB);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rsa_stop_restorer.sv
module rsa_stop_restorer
  import rsa_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 80,
  parameter int unsigned FIFO_DEPTH    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_bit,
  input  logic       sync_en,
  input  logic       tick,
  input  logic [1:0] char_len,
  input  logic       ovs_ext,
  output logic       rxd
);

  localparam int unsigned CNTW = $clog2(FIFO_DEPTH + 1);

  logic                push;
  entry_t              push_entry;
  logic                in_break;
  logic                pop;
  logic [ENTRY_W-1:0]  rd_vec;
  entry_t              head;
  logic [CNTW-1:0]     f_count;
  logic                f_empty;
  logic                f_full;
  logic                ser_idle;
  logic                ser_break;

  rsa_framer u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_bit   (sync_bit),
    .sync_en    (sync_en),
    .char_len   (char_len),
    .push       (push),
    .push_entry (push_entry),
    .in_break   (in_break)
  );

  rsa_char_fifo #(
    .DEPTH (FIFO_DEPTH),
    .W     (ENTRY_W),
    .CNTW  (CNTW)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata (push_entry),
    .pop   (pop),
    .rdata (rd_vec),
    .count (f_count),
    .empty (f_empty),
    .full  (f_full)
  );

  assign head = rd_vec;

  rsa_serializer #(
    .TPB  (TICKS_PER_BIT),
    .CNTW (CNTW)
  ) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .ovs_ext    (ovs_ext),
    .char_len   (char_len),
    .fifo_empty (f_empty),
    .fifo_count (f_count),
    .head       (head),
    .in_break   (in_break),
    .pop        (pop),
    .rxd        (rxd),
    .ser_idle   (ser_idle),
    .ser_break  (ser_break)
  );

endmodule

// File: rtl/rsa_checks.sv
module rsa_checks #(
  parameter int unsigned TPB = 80
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic sync_en,
  input logic rxd,
  input logic push,
  input logic pop,
  input logic fifo_full,
  input logic fifo_empty,
  input logic ser_idle,
  input logic ser_break
);

  localparam int unsigned RUN_MIN = (TPB * 7) / 8;

  logic [15:0] run_ticks;
  logic        last_rxd;
  logic        seen_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_ticks <= '0;
      last_rxd  <= 1'b1;
      seen_edge <= 1'b0;
    end else begin
      last_rxd <= rxd;
      if (rxd != last_rxd) begin
        run_ticks <= {15'd0, tick};
        seen_edge <= 1'b1;
      end else if (tick && run_ticks != 16'hFFFF) begin
        run_ticks <= run_ticks + 16'd1;
      end
    end
  end

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_idle && fifo_empty) |-> rxd);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!fifo_full || pop));

  a_r6_break_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_break && $past(ser_break)) |-> $stable(rxd));

  // R4 and R5: no level on the line is shorter than a shortened stop bit
  a_r4_run_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rxd) && seen_edge) |-> (run_ticks >= 16'(RUN_MIN)));

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_en |=> !sync_en);

endmodule

bind rsa_stop_restorer rsa_checks #(.TPB(TICKS_PER_BIT)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .sync_en    (sync_en),
  .rxd        (rxd),
  .push       (push),
  .pop        (pop),
  .fifo_full  (f_full),
  .fifo_empty (f_empty),
  .ser_idle   (ser_idle),
  .ser_break  (ser_break)
);

// File: tb/sim_rsa_stop_restorer.sv
module sim_rsa_stop_restorer;

  localparam int TPB = 80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_bit = 1'b1;
  logic       sync_en = 1'b0;
  logic       tick = 1'b1;
  logic [1:0] char_len = 2'd2;
  logic       ovs_ext = 1'b0;
  logic       rxd;

  always #4 clk = ~clk;

  rsa_stop_restorer #(.TICKS_PER_BIT(TPB)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_bit(sync_bit), .sync_en(sync_en),
    .tick(tick), .char_len(char_len), .ovs_ext(ovs_ext), .rxd(rxd)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // line monitor and reference decoder
  logic [8:0] rx_dat [64];
  int   rx_cnt = 0, rx_ferr = 0;
  bit   dec_en = 1'b1, busy = 1'b0;
  int   dt = 0, kk = 0, cur_d = 8;
  logic [8:0] acc = '0;
  logic prev = 1'b1;
  int   run = 0, min_run = 1000000, seen70 = 0, falls = 0, last_low = 0, edges = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rxd == prev) run++;
      else begin
        edges++;
        if (edges > 1 && run < min_run) min_run = run;
        if (prev && run == 70) seen70++;
        if (!prev) last_low = run;
        if (prev) falls++;
        run = 1;
      end
      if (!busy) begin
        if (dec_en && prev && !rxd) begin busy = 1'b1; dt = 0; acc = '0; end
      end else begin
        dt++;
        if (dt == 40) begin
          if (rxd) busy = 1'b0;
        end else if (dt > 40 && (dt - 40) % 80 == 0) begin
          kk = (dt - 40) / 80;
          if (kk <= cur_d) acc[kk-1] = rxd;
          else begin
            if (rxd) begin
              if (rx_cnt < 64) rx_dat[rx_cnt] = acc;
              rx_cnt++;
            end else rx_ferr++;
            busy = 1'b0;
          end
        end
      end
    end
    prev = rxd;
  end

  logic [8:0] exp_dat [16];
  int exp_n = 0;

  task automatic begin_test();
    rx_cnt = 0; rx_ferr = 0; exp_n = 0; min_run = 1000000; seen70 = 0;
  endtask

  task automatic send_bit(input logic b, input int p);
    @(negedge clk); sync_bit = b; sync_en = 1'b1;
    @(negedge clk); sync_en = 1'b0;
    repeat (p - 2) @(negedge clk);
  endtask

  // stop=0 leaves the stop position to the next frame's start bit
  task automatic send_char(input logic [8:0] d, input bit stop, input int p);
    send_bit(1'b0, p);
    for (int k = 0; k < cur_d; k++) send_bit(d[k], p);
    if (stop) send_bit(1'b1, p);
    if (exp_n < 16) exp_dat[exp_n] = d;
    exp_n++;
  endtask

  task automatic settle();
    repeat (4) send_bit(1'b1, 80);
    repeat (1600) @(negedge clk);
  endtask

  task automatic check_rx(input string req);
    chk(rx_cnt == exp_n, req, rx_cnt, exp_n);
    for (int i = 0; i < exp_n && i < rx_cnt; i++)
      chk(rx_dat[i] == exp_dat[i], req, int'(rx_dat[i]), int'(exp_dat[i]));
    chk(rx_ferr == 0, req, rx_ferr, 0);
  endtask

  task automatic set_len(input logic [1:0] l);
    char_len = l;
    cur_d = 6 + int'(l);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(rxd == 1'b1, "R1 in reset", int'(rxd), 1);
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    chk(rxd == 1'b1, "R1 after reset", int'(rxd), 1);
  endtask

  task automatic t_lengths();
    begin_test(); set_len(2'd2);
    send_char(9'h0A5, 1, 80); send_char(9'h03C, 1, 80); send_char(9'h0FF, 1, 80);
    settle(); check_rx("R2 N=10");
    begin_test(); set_len(2'd0);
    send_char(9'h02D, 1, 80); send_char(9'h012, 1, 80);
    settle(); check_rx("R2 N=8");
    begin_test(); set_len(2'd3);
    send_char(9'h1B3, 1, 80); send_char(9'h0F0, 1, 80);
    settle(); check_rx("R2 N=11");
    begin_test(); set_len(2'd2);
    send_char(9'h000, 1, 80);
    settle(); check_rx("R4 lone zero");
    chk(last_low == 9 * TPB, "R4 full-length bits", last_low, 9 * TPB);
  endtask

  task automatic t_deleted_stop();
    begin_test(); set_len(2'd2);
    send_char(9'h011, 1, 80); send_char(9'h022, 0, 80); send_char(9'h033, 1, 80);
    send_char(9'h044, 0, 80); send_char(9'h055, 1, 80);
    settle(); check_rx("R3 restored stops");
    chk(min_run >= 79, "R4 rate ceiling", min_run, 79);
  endtask

  task automatic t_zero_pair();
    begin_test(); set_len(2'd2);
    send_char(9'h000, 0, 80); send_char(9'h05A, 1, 80);
    settle(); check_rx("R7 zero then data");
    begin_test();
    send_char(9'h000, 0, 80); send_char(9'h000, 1, 80);
    settle(); check_rx("R7 zero then stop-only one");
  endtask

  task automatic t_break();
    int f0;
    begin_test(); set_len(2'd2); dec_en = 1'b0;
    f0 = falls;
    repeat (30) send_bit(1'b0, 80);
    repeat (6) send_bit(1'b1, 80);
    repeat (1200) @(negedge clk);
    chk(falls - f0 == 1, "R6 single low", falls - f0, 1);
    chk(last_low >= 9 * TPB, "R6 break length", last_low, 9 * TPB);
    chk(rxd == 1'b1, "R6 high after break", int'(rxd), 1);
    dec_en = 1'b1;
    begin_test();
    send_char(9'h0C3, 1, 80);
    settle(); check_rx("R6 recovery");
  endtask

  task automatic t_ext();
    begin_test(); set_len(2'd2); ovs_ext = 1'b1;
    send_char(9'h015, 1, 78); send_char(9'h02A, 1, 78); send_char(9'h035, 1, 78);
    send_char(9'h04B, 1, 78); send_char(9'h061, 1, 78); send_char(9'h07E, 1, 78);
    settle(); check_rx("R8 ext overspeed");
    chk(seen70 > 0, "R5 short stop seen", seen70, 1);
    chk(min_run >= 70, "R5 stop floor", min_run, 70);
    ovs_ext = 1'b0;
  endtask

  task automatic t_normal_overspeed();
    begin_test(); set_len(2'd2);
    send_char(9'h09C, 1, 79); send_char(9'h0E1, 1, 79); send_char(9'h047, 1, 79);
    send_char(9'h0B8, 1, 79);
    settle(); check_rx("R8 normal overspeed");
    chk(min_run >= 79, "R4 no short run", min_run, 79);
    chk(rxd == 1'b1, "R1 idle at end", int'(rxd), 1);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_lengths();
    t_deleted_stop();
    t_zero_pair();
    t_break();
    t_ext();
    t_normal_overspeed();
    summary();
    $finish;
  end

endmodule